// File: doc/BRIEF.md
# Auxiliary Output Pin Controller

This block owns one three-state output pin that a system can use either to enable an external voltage regulator or to flag a degraded "limp-home" condition to the rest of the board. It keeps two configuration bits, a drive-enable bit and a drive-level bit. Together they select one of three pin states: not driven (floating), driven LOW or driven HIGH. The block hands a drive-enable and a drive-level to an external tri-state pad. Pull resistors and the pad itself sit outside the block.

Software changes the pin through a single-cycle write strobe that carries both bits. A supervising mode controller also sends one-cycle event pulses when the system enters fail-safe, restart, sleep or start-up. Start-up pulses carry a cause code. Some of these events pull the pin LOW without software action. When that happens the block rewrites its own configuration bits, so that a readback always matches the pin.

The write strobe and the event pulses are plain control inputs. They are always accepted and there is no back-pressure. A write that shares its cycle with any event pulse is discarded, because the event takes priority. Every change becomes visible on the outputs one clock after the edge that captures it.

Top module: `aux_out_ctl`

## Requirements
- R1: While reset is asserted, and after it is released, the pin is floating: pad_oe=0, pad_lvl=0, state_code=00, rd_en=0, rd_lvl=0.
- R2: When the stored enable bit is 0, the pin floats (pad_oe=0) whatever the stored level bit holds. rd_lvl still reports the stored level.
- R3: When the stored enable bit is 1, a stored level of 1 drives the pin HIGH (pad_oe=1, pad_lvl=1) and a stored level of 0 drives it LOW (pad_oe=1, pad_lvl=0).
- R4: A write (cfg_wr=1 with no event pulse in that cycle) loads cfg_en and cfg_lvl. A write can move the pin between any two of the three states, and the new state appears on the outputs after that clock edge.
- R5: A fail-safe pulse forces the pin LOW from every state and sets rd_en=1, rd_lvl=0.
- R6: A restart or sleep pulse moves the pin from HIGH to LOW (rd_en=1, rd_lvl=0). From floating or LOW, such a pulse leaves the state unchanged.
- R7: A start-up pulse moves the pin from HIGH to LOW only when startup_cause is 1 (wake-up reset), 2 (external reset) or 3 (supply undervoltage). Every other cause code, and every start-up pulse while the pin is not HIGH, leaves the state unchanged.
- R8: When cfg_wr coincides with any event pulse, the write is discarded. The state becomes whatever the event alone produces.
- R9: state_code reports 00 for floating, 01 for LOW and 10 for HIGH, and never 11. pad_lvl is 0 whenever pad_oe is 0.
- R10: With no write and no event pulse, the state holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_en | input | 1 | Write data: drive-enable bit |
| cfg_lvl | input | 1 | Write data: drive-level bit |
| ev_failsafe | input | 1 | Pulse: entering fail-safe mode |
| ev_restart | input | 1 | Pulse: entering restart mode |
| ev_sleep | input | 1 | Pulse: entering sleep mode |
| ev_startup | input | 1 | Pulse: entering start-up mode |
| startup_cause | input | CAUSE_W | Start-up cause code, valid with ev_startup |
| pad_oe | output | 1 | Pad drive enable |
| pad_lvl | output | 1 | Pad drive level |
| state_code | output | 2 | Pin state: 00 floating, 01 LOW, 10 HIGH |
| rd_en | output | 1 | Readback of the stored enable bit |
| rd_lvl | output | 1 | Readback of the stored level bit |

## Verification
The whole state lives in two flops. A wrong state therefore shows on pad_oe, pad_lvl, state_code and the readback bits one clock after the edge that caused it, and the fault stays visible until the next write or forcing event. The bench compares all six output bits against a model after every cycle. It puts each event in turn against the HIGH, LOW and floating states, tries every start-up cause code, and pairs writes with events in the same cycle. A mis-decoded cause, a dropped priority or a stale readback is therefore caught the cycle after it occurs.

// File: rtl/aux_pkg.sv
package aux_pkg;
  typedef enum logic [1:0] {
    ST_FLOAT = 2'b00,
    ST_LOW   = 2'b01,
    ST_HIGH  = 2'b10
  } aux_state_e;
endpackage

// File: rtl/aux_evt_dec.sv
// Reduces mode-controller pulses into three control terms for the state register.
module aux_evt_dec #(
  parameter int CAUSE_W = 3,
  parameter logic [(1<<CAUSE_W)-1:0] FORCE_MASK = 8'b0000_1110
) (
  input  logic               ev_failsafe,
  input  logic               ev_restart,
  input  logic               ev_sleep,
  input  logic               ev_startup,
  input  logic [CAUSE_W-1:0] startup_cause,
  output logic               ev_any,
  output logic               force_always,
  output logic               force_if_high
);
  localparam int N_CAUSE = 1 << CAUSE_W;

  logic [N_CAUSE-1:0] cause_hit;
  logic               cause_forces;

  // one comparator per cause code, kept only where the mask marks it (R7)
  for (genvar i = 0; i < N_CAUSE; i++) begin : g_cause
    if (FORCE_MASK[i]) begin : g_on
      assign cause_hit[i] = (startup_cause == CAUSE_W'(i));
    end else begin : g_off
      assign cause_hit[i] = 1'b0;
    end
  end

  assign cause_forces  = |cause_hit;
  assign ev_any        = ev_failsafe | ev_restart | ev_sleep | ev_startup;
  assign force_always  = ev_failsafe;
  assign force_if_high = ev_restart | ev_sleep | (ev_startup & cause_forces);
endmodule

// File: rtl/aux_state_reg.sv
// Holds the enable and level bits; events take priority over writes.
module aux_state_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_wr,
  input  logic cfg_en,
  input  logic cfg_lvl,
  input  logic ev_any,
  input  logic force_always,
  input  logic force_if_high,
  output logic en_q,
  output logic lvl_q
);
  logic is_high;
  logic do_force;
  logic en_d;
  logic lvl_d;

  assign is_high  = en_q & lvl_q;
  assign do_force = force_always | (force_if_high & is_high);

  always_comb begin
    en_d  = en_q;
    lvl_d = lvl_q;
    if (do_force) begin
      en_d  = 1'b1;
      lvl_d = 1'b0;
    end else if (!ev_any && cfg_wr) begin
      en_d  = cfg_en;
      lvl_d = cfg_lvl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      lvl_q <= 1'b0;
    end else begin
      en_q  <= en_d;
      lvl_q <= lvl_d;
    end
  end

  p_reset_float_r1: assert property (@(posedge clk)
    !rst_n |-> (!en_q && !lvl_q));

  p_write_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !ev_any) |=> (en_q == $past(cfg_en) && lvl_q == $past(cfg_lvl)));

  p_failsafe_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    force_always |=> (en_q && !lvl_q));

  p_high_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (force_if_high && en_q && lvl_q) |=> (en_q && !lvl_q));

  p_write_lost_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && ev_any && !force_always && !(force_if_high && en_q && lvl_q))
      |=> $stable({en_q, lvl_q}));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_wr && !ev_any) |=> $stable({en_q, lvl_q}));
endmodule

// File: rtl/aux_pad_enc.sv
// Maps the stored bits to pad controls and the state code.
module aux_pad_enc
  import aux_pkg::*;
(
  input  logic       en_q,
  input  logic       lvl_q,
  output logic       pad_oe,
  output logic       pad_lvl,
  output logic [1:0] state_code
);
  aux_state_e st;

  always_comb begin
    if (!en_q)      st = ST_FLOAT;
    else if (lvl_q) st = ST_HIGH;
    else            st = ST_LOW;
  end

  assign state_code = st;
  assign pad_oe     = (st != ST_FLOAT);
  assign pad_lvl    = (st == ST_HIGH);
endmodule

// File: rtl/aux_out_ctl.sv
module aux_out_ctl #(
  parameter int CAUSE_W = 3,
  parameter logic [(1<<CAUSE_W)-1:0] FORCE_MASK = 8'b0000_1110
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr,
  input  logic               cfg_en,
  input  logic               cfg_lvl,
  input  logic               ev_failsafe,
  input  logic               ev_restart,
  input  logic               ev_sleep,
  input  logic               ev_startup,
  input  logic [CAUSE_W-1:0] startup_cause,
  output logic               pad_oe,
  output logic               pad_lvl,
  output logic [1:0]         state_code,
  output logic               rd_en,
  output logic               rd_lvl
);
  logic ev_any;
  logic force_always;
  logic force_if_high;
  logic en_q;
  logic lvl_q;

  aux_evt_dec #(.CAUSE_W(CAUSE_W), .FORCE_MASK(FORCE_MASK)) u_dec (
    .ev_failsafe  (ev_failsafe),
    .ev_restart   (ev_restart),
    .ev_sleep     (ev_sleep),
    .ev_startup   (ev_startup),
    .startup_cause(startup_cause),
    .ev_any       (ev_any),
    .force_always (force_always),
    .force_if_high(force_if_high)
  );

  aux_state_reg u_reg (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_wr       (cfg_wr),
    .cfg_en       (cfg_en),
    .cfg_lvl      (cfg_lvl),
    .ev_any       (ev_any),
    .force_always (force_always),
    .force_if_high(force_if_high),
    .en_q         (en_q),
    .lvl_q        (lvl_q)
  );

  aux_pad_enc u_enc (
    .en_q      (en_q),
    .lvl_q     (lvl_q),
    .pad_oe    (pad_oe),
    .pad_lvl   (pad_lvl),
    .state_code(state_code)
  );

  assign rd_en  = en_q;
  assign rd_lvl = lvl_q;

  p_code_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code != 2'b11) && (!pad_oe -> !pad_lvl));

  p_float_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (!pad_oe && state_code == 2'b00));

  p_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (pad_oe && pad_lvl == rd_lvl));
endmodule

// File: tb/test_aux_out_ctl.sv
module test_aux_out_ctl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0, cfg_en = 1'b0, cfg_lvl = 1'b0;
  logic       ev_failsafe = 1'b0, ev_restart = 1'b0, ev_sleep = 1'b0, ev_startup = 1'b0;
  logic [2:0] startup_cause = 3'd0;
  logic       pad_oe, pad_lvl, rd_en, rd_lvl;
  logic [1:0] state_code;

  int n_checks = 0;
  int n_errors = 0;
  logic m_en = 1'b0, m_lvl = 1'b0;

  always #4 clk = ~clk;

  aux_out_ctl i_aux_out_ctl (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_en(cfg_en), .cfg_lvl(cfg_lvl),
    .ev_failsafe(ev_failsafe), .ev_restart(ev_restart), .ev_sleep(ev_sleep),
    .ev_startup(ev_startup), .startup_cause(startup_cause),
    .pad_oe(pad_oe), .pad_lvl(pad_lvl), .state_code(state_code),
    .rd_en(rd_en), .rd_lvl(rd_lvl)
  );

  // expected {pad_oe, pad_lvl, state_code, rd_en, rd_lvl}
  function automatic logic [5:0] exp_vec(input logic en, input logic lvl);
    logic [1:0] code;
    code = !en ? 2'b00 : (lvl ? 2'b10 : 2'b01);
    return {en, en & lvl, code, en, lvl};
  endfunction

  function automatic logic cause_forces(input logic [2:0] c);
    return (c == 3'd1) || (c == 3'd2) || (c == 3'd3);
  endfunction

  task automatic check(input string tag, input logic [5:0] exp);
    logic [5:0] got;
    got = {pad_oe, pad_lvl, state_code, rd_en, rd_lvl};
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  // drive one cycle of stimulus, update the model, check after the edge
  task automatic step(input string tag, input logic wr, input logic en, input logic lvl,
                      input logic fs, input logic rs, input logic sl, input logic su,
                      input logic [2:0] cause);
    logic hi, evany;
    cfg_wr = wr; cfg_en = en; cfg_lvl = lvl;
    ev_failsafe = fs; ev_restart = rs; ev_sleep = sl; ev_startup = su;
    startup_cause = cause;
    hi    = m_en & m_lvl;
    evany = fs | rs | sl | su;
    if (fs || (hi && (rs || sl || (su && cause_forces(cause))))) begin
      m_en = 1'b1; m_lvl = 1'b0;
    end else if (wr && !evany) begin
      m_en = en; m_lvl = lvl;
    end
    @(posedge clk);
    @(negedge clk);
    cfg_wr = 1'b0; ev_failsafe = 1'b0; ev_restart = 1'b0; ev_sleep = 1'b0; ev_startup = 1'b0;
    check(tag, exp_vec(m_en, m_lvl));
  endtask

  task automatic wr(input string tag, input logic en, input logic lvl);
    step(tag, 1'b1, en, lvl, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0);
  endtask

  initial begin : watchdog
    #1_000_000;
    n_errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks + 1, n_errors);
    $finish;
  end

  initial begin : main
    int unsigned seed;
    seed = 32'd20240611;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    check("R1 in reset", exp_vec(1'b0, 1'b0));
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", exp_vec(1'b0, 1'b0));

    wr("R2 float with level 1, R9 pad_lvl 0", 1'b0, 1'b1);
    wr("R3 drive HIGH", 1'b1, 1'b1);
    wr("R3 drive LOW", 1'b1, 1'b0);
    wr("R4 LOW to float", 1'b0, 1'b0);
    wr("R4 float to LOW", 1'b1, 1'b0);
    wr("R4 LOW to HIGH", 1'b1, 1'b1);
    wr("R4 HIGH to float", 1'b0, 1'b1);
    step("R10 idle hold float", 0, 0, 0, 0, 0, 0, 0, 3'd0);

    step("R6 sleep from float ignored", 0, 0, 0, 0, 0, 1, 0, 3'd0);
    step("R6 restart from float ignored", 0, 0, 0, 0, 1, 0, 0, 3'd0);
    step("R5 fail-safe from float", 0, 0, 0, 1, 0, 0, 0, 3'd0);
    step("R6 sleep from LOW ignored", 0, 0, 0, 0, 0, 1, 0, 3'd0);
    wr("R4 to HIGH", 1'b1, 1'b1);
    step("R6 restart from HIGH", 0, 0, 0, 0, 1, 0, 0, 3'd0);
    wr("R4 to HIGH", 1'b1, 1'b1);
    step("R6 sleep from HIGH", 0, 0, 0, 0, 0, 1, 0, 3'd0);
    wr("R4 to HIGH", 1'b1, 1'b1);
    step("R5 fail-safe from HIGH", 0, 0, 0, 1, 0, 0, 0, 3'd0);
    step("R5 fail-safe from LOW", 0, 0, 0, 1, 0, 0, 0, 3'd0);

    for (int c = 0; c < 8; c++) begin
      wr("R4 to HIGH", 1'b1, 1'b1);
      step("R7 start-up cause from HIGH", 0, 0, 0, 0, 0, 0, 1, 3'(c));
    end
    wr("R4 to float", 1'b0, 1'b1);
    step("R7 start-up cause 2 from float ignored", 0, 0, 0, 0, 0, 0, 1, 3'd2);

    wr("R4 to HIGH", 1'b1, 1'b1);
    step("R8 write float lost to sleep", 1, 0, 0, 0, 0, 1, 0, 3'd0);
    step("R8 write HIGH lost to start-up cause 5", 1, 1, 1, 0, 0, 0, 1, 3'd5);
    wr("R4 to float", 1'b0, 1'b0);
    step("R8 write HIGH lost to fail-safe", 1, 1, 1, 1, 0, 0, 0, 3'd0);
    wr("R4 to float", 1'b0, 1'b0);
    step("R8 write HIGH lost to restart from float", 1, 1, 1, 0, 1, 0, 0, 3'd0);

    for (int i = 0; i < 600; i++) begin
      logic w, e, l, fs, rs, sl, su;
      logic [2:0] cs;
      string tag;
      w  = ($urandom % 100) < 40;
      e  = $urandom % 2;
      l  = $urandom % 2;
      fs = ($urandom % 100) < 6;
      rs = ($urandom % 100) < 8;
      sl = ($urandom % 100) < 8;
      su = ($urandom % 100) < 12;
      cs = 3'($urandom % 8);
      if (fs) tag = "R5 random fail-safe";
      else if (w && (rs || sl || su)) tag = "R8 random write with event";
      else if (su) tag = "R7 random start-up";
      else if (rs || sl) tag = "R6 random restart/sleep";
      else if (w) tag = "R4 random write";
      else tag = "R10 random idle";
      step(tag, w, e, l, fs, rs, sl, su, cs);
    end

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule